// File: doc/BRIEF.md
# Register-Configured Pad Multiplexer

This block sits between a bank of bidirectional pad cells and a set of peripheral functions. Each pad has its own select register. The value in that register decides which peripheral function owns the pad. One setting moves three routes at once: the outgoing data, the output-enable, and the incoming pad value. Because of this, a single write can hand a bidirectional pad, direction control included, to a peripheral.

Software programs the select registers through a plain address/data port. The port reports an error for any index that no pad owns. The register index comes from a configurable slice of the address. The select registers feed the routing logic directly on every cycle, with no handshake.

Peripheral functions come in three kinds:

- Input-only functions receive from the pad.
- Output-only functions drive the pad with output-enable held high.
- Bidirectional functions drive both data and output-enable themselves and also receive the pad value.

Top module: `padmux`

## Requirements
- R1: After reset every select register holds 0, so every pad has pad_out=0 and pad_oe=0, every fn_in bit is 0, and every mapped index reads back 0 without error.
- R2: A write with cfg_wr=1 to a mapped index stores cfg_wdata[SEL_W-1:0] at the next rising clock edge, and the upper data bits are dropped. A read of that index returns the value zero-extended to DATA_W with cfg_rd_err=0.
- R3: An index of NUM_PADS or above is unmapped. A write to it raises cfg_wr_err in the same cycle and changes no register. A read of it gives cfg_rd_err=1 and cfg_rdata=0.
- R4: The index is cfg_addr[IDX_HI:IDX_LO], and index k selects pad k. Address bits outside that slice have no effect. With the defaults, pad k sits at address 4k.
- R5: Select value 0 leaves a pad idle (pad_out=0, pad_oe=0, feeding no function). A value c from 1 to 2^SEL_W-1 on pad p connects function (p+c-1) mod NUM_FUNCS.
- R6: A pad connected to an output-only function (kind code 1) drives that function's fn_out bit with pad_oe=1.
- R7: A pad connected to a bidirectional function (kind code 2) takes both pad_out and pad_oe from that function's fn_out and fn_oe bits, and returns pad_in to its fn_in bit.
- R8: A pad connected to an input-only function (kind code 0) holds pad_out=0 and pad_oe=0 and returns pad_in to that function's fn_in bit.
- R9: An fn_in bit reads 0 when no pad is connected to that function or when the function is output-only.
- R10: When several pads connect the same input-capable function, its fn_in bit follows the lowest-numbered of those pads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for the select registers |
| cfg_addr | input | ADDR_W | Register address, shared by reads and writes |
| cfg_wdata | input | DATA_W | Write data |
| cfg_wr_err | output | 1 | Write targets an unmapped index |
| cfg_rdata | output | DATA_W | Zero-extended select value at cfg_addr |
| cfg_rd_err | output | 1 | cfg_addr holds an unmapped index |
| pad_out | output | NUM_PADS | Data towards each pad |
| pad_oe | output | NUM_PADS | Output-enable towards each pad |
| pad_in | input | NUM_PADS | Value coming back from each pad |
| fn_out | input | NUM_FUNCS | Data from each peripheral function |
| fn_oe | input | NUM_FUNCS | Output-enable from each peripheral function |
| fn_in | output | NUM_FUNCS | Value returned to each peripheral function |

## Verification
The bench gives two pads the same input-capable function and drives them to opposite levels. A design without lowest-pad priority would return the higher pad's value. It writes a data word with its upper bits set, which would read back wrong if the design failed to truncate it. It also accesses the same register through an alias address with stray bits outside the index slice, which exposes decoding that looks at those bits. Unmapped writes must raise the error flag and leave every register unchanged, and a corrupting design would show altered read-backs. A bidirectional pad is driven with its output-enable low and then high, so a design that routed only data, or forced the enable, would show the wrong pad_oe.

// File: rtl/padmux_pkg.sv
package padmux_pkg;

   // kind code of a peripheral function, two bits per function in FUNC_KIND
   typedef enum logic [1:0] {
      FK_IN    = 2'd0,
      FK_OUT   = 2'd1,
      FK_BIDIR = 2'd2
   } fn_kind_e;

   // function reached from pad `pad` with non-zero choice `choice`
   function automatic int fn_of(input int pad, input int choice, input int nfuncs);
      return (pad + choice - 1) % nfuncs;
   endfunction

endpackage

// File: rtl/padmux_regfile.sv
module padmux_regfile #(
   parameter int NUM_PADS = 4,
   parameter int SEL_W    = 2,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int IDX_LO   = 2,
   parameter int IDX_HI   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_wr,
   input  logic [ADDR_W-1:0]          cfg_addr,
   input  logic [DATA_W-1:0]          cfg_wdata,
   output logic                       cfg_wr_err,
   output logic [DATA_W-1:0]          cfg_rdata,
   output logic                       cfg_rd_err,
   output logic [NUM_PADS*SEL_W-1:0]  sel_flat
);

   localparam int IDX_W = IDX_HI - IDX_LO + 1;

   logic [IDX_W-1:0]    idx;
   logic                hit;
   logic [NUM_PADS-1:0] pad_hit;
   logic [SEL_W-1:0]    rd_acc [NUM_PADS+1];
   logic                unused_cfg_bits;

   assign idx = cfg_addr[IDX_HI:IDX_LO];
   assign hit = (32'(idx) < NUM_PADS);
   assign unused_cfg_bits = ^{cfg_addr, cfg_wdata};

   assign rd_acc[0] = '0;

   for (genvar k = 0; k < NUM_PADS; k++) begin : g_sel
      logic [SEL_W-1:0] sel_q;

      assign pad_hit[k] = hit && (idx == IDX_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q <= '0;
         end else if (cfg_wr && pad_hit[k]) begin
            sel_q <= cfg_wdata[SEL_W-1:0];
         end
      end

      assign sel_flat[k*SEL_W +: SEL_W] = sel_q;
      assign rd_acc[k+1] = rd_acc[k] | (pad_hit[k] ? sel_q : '0);

      // R2: a mapped write lands in exactly this pad's register one edge later
      a_r2_write_stores: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_wr && pad_hit[k]) |=> (sel_flat[k*SEL_W +: SEL_W] == $past(cfg_wdata[SEL_W-1:0])));
   end

   assign cfg_rdata  = DATA_W'(rd_acc[NUM_PADS]);
   assign cfg_rd_err = !hit;
   assign cfg_wr_err = cfg_wr && !hit;

   // R3: an unmapped write leaves every select register untouched
   a_r3_bad_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wr_err) |=> $stable(sel_flat));

   // R3: an unmapped read returns zero data
   a_r3_bad_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_err |-> (cfg_rdata == '0));

   // R4: at most one register is addressed at a time
   a_r4_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pad_hit));

endmodule

// File: rtl/padmux_out_path.sv
module padmux_out_path
   import padmux_pkg::*;
#(
   parameter int                       NUM_PADS  = 4,
   parameter int                       SEL_W     = 2,
   parameter int                       NUM_FUNCS = 6,
   parameter logic [2*NUM_FUNCS-1:0]   FUNC_KIND = 12'h186
) (
   input  logic [NUM_PADS*SEL_W-1:0]  sel_flat,
   input  logic [NUM_FUNCS-1:0]       fn_out,
   input  logic [NUM_FUNCS-1:0]       fn_oe,
   output logic [NUM_PADS-1:0]        pad_out,
   output logic [NUM_PADS-1:0]        pad_oe
);

   localparam int CHOICES = 1 << SEL_W;

   logic unused_fn_bits;
   assign unused_fn_bits = ^{fn_out, fn_oe};

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      logic [CHOICES-1:0] cand_out;
      logic [CHOICES-1:0] cand_oe;
      logic [SEL_W-1:0]   choice;

      assign choice = sel_flat[p*SEL_W +: SEL_W];

      for (genvar c = 0; c < CHOICES; c++) begin : g_choice
         if (c == 0) begin : g_idle
            assign cand_out[c] = 1'b0;
            assign cand_oe[c]  = 1'b0;
         end else begin : g_fn
            localparam int          FN   = fn_of(p, c, NUM_FUNCS);
            localparam logic [1:0]  KIND = FUNC_KIND[2*FN+1 -: 2];
            if (KIND == FK_OUT) begin : g_out
               assign cand_out[c] = fn_out[FN];
               assign cand_oe[c]  = 1'b1;
            end else if (KIND == FK_BIDIR) begin : g_bidir
               assign cand_out[c] = fn_out[FN];
               assign cand_oe[c]  = fn_oe[FN];
            end else begin : g_in
               assign cand_out[c] = 1'b0;
               assign cand_oe[c]  = 1'b0;
            end
         end
      end

      assign pad_out[p] = cand_out[choice];
      assign pad_oe[p]  = cand_oe[choice];
   end

endmodule

// File: rtl/padmux_in_path.sv
module padmux_in_path
   import padmux_pkg::*;
#(
   parameter int                       NUM_PADS  = 4,
   parameter int                       SEL_W     = 2,
   parameter int                       NUM_FUNCS = 6,
   parameter logic [2*NUM_FUNCS-1:0]   FUNC_KIND = 12'h186
) (
   input  logic [NUM_PADS*SEL_W-1:0]  sel_flat,
   input  logic [NUM_PADS-1:0]        pad_in,
   output logic [NUM_FUNCS-1:0]       fn_in
);

   localparam int CHOICES = 1 << SEL_W;

   logic unused_in_bits;
   assign unused_in_bits = ^{sel_flat, pad_in};

   for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn
      localparam logic [1:0] KIND = FUNC_KIND[2*f+1 -: 2];

      if (KIND == FK_OUT) begin : g_no_return
         assign fn_in[f] = 1'b0;
      end else begin : g_return
         logic [NUM_PADS-1:0] claims;
         logic [NUM_PADS-1:0] winner;

         for (genvar p = 0; p < NUM_PADS; p++) begin : g_claim
            always_comb begin
               claims[p] = 1'b0;
               for (int c = 1; c < CHOICES; c++) begin
                  if ((fn_of(p, c, NUM_FUNCS) == f) &&
                      (sel_flat[p*SEL_W +: SEL_W] == SEL_W'(c))) begin
                     claims[p] = 1'b1;
                  end
               end
            end
         end

         // isolate the lowest claiming pad
         assign winner   = claims & (~claims + NUM_PADS'(1));
         assign fn_in[f] = |(winner & pad_in);
      end
   end

endmodule

// File: rtl/padmux.sv
module padmux
   import padmux_pkg::*;
#(
   parameter int                       NUM_PADS  = 4,
   parameter int                       SEL_W     = 2,
   parameter int                       NUM_FUNCS = 6,
   parameter logic [2*NUM_FUNCS-1:0]   FUNC_KIND = 12'h186,
   parameter int                       DATA_W    = 32,
   parameter int                       ADDR_W    = 8,
   parameter int                       IDX_LO    = 2,
   parameter int                       IDX_HI    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [ADDR_W-1:0]      cfg_addr,
   input  logic [DATA_W-1:0]      cfg_wdata,
   output logic                   cfg_wr_err,
   output logic [DATA_W-1:0]      cfg_rdata,
   output logic                   cfg_rd_err,
   output logic [NUM_PADS-1:0]    pad_out,
   output logic [NUM_PADS-1:0]    pad_oe,
   input  logic [NUM_PADS-1:0]    pad_in,
   input  logic [NUM_FUNCS-1:0]   fn_out,
   input  logic [NUM_FUNCS-1:0]   fn_oe,
   output logic [NUM_FUNCS-1:0]   fn_in
);

   localparam int IDX_W = IDX_HI - IDX_LO + 1;

   // elaboration-time parameter checks
   if (NUM_PADS < 1 || NUM_FUNCS < 1 || SEL_W < 1) begin : g_bad_size
      $error("padmux: NUM_PADS, NUM_FUNCS and SEL_W must be positive");
   end
   if (SEL_W > DATA_W) begin : g_bad_sel
      $error("padmux: SEL_W exceeds DATA_W");
   end
   if (IDX_LO < 0 || IDX_HI < IDX_LO || IDX_HI >= ADDR_W || IDX_W > 31) begin : g_bad_slice
      $error("padmux: index slice outside the address bus");
   end
   if ((1 << IDX_W) < NUM_PADS) begin : g_bad_reach
      $error("padmux: index slice too narrow for NUM_PADS");
   end
   for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_kind_chk
      if (FUNC_KIND[2*f+1 -: 2] == 2'b11) begin : g_bad_kind
         $error("padmux: undefined function kind code");
      end
   end

   logic [NUM_PADS*SEL_W-1:0] sel_flat;

   padmux_regfile #(
      .NUM_PADS (NUM_PADS),
      .SEL_W    (SEL_W),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .IDX_LO   (IDX_LO),
      .IDX_HI   (IDX_HI)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_wr_err (cfg_wr_err),
      .cfg_rdata  (cfg_rdata),
      .cfg_rd_err (cfg_rd_err),
      .sel_flat   (sel_flat)
   );

   padmux_out_path #(
      .NUM_PADS  (NUM_PADS),
      .SEL_W     (SEL_W),
      .NUM_FUNCS (NUM_FUNCS),
      .FUNC_KIND (FUNC_KIND)
   ) u_out (
      .sel_flat (sel_flat),
      .fn_out   (fn_out),
      .fn_oe    (fn_oe),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   padmux_in_path #(
      .NUM_PADS  (NUM_PADS),
      .SEL_W     (SEL_W),
      .NUM_FUNCS (NUM_FUNCS),
      .FUNC_KIND (FUNC_KIND)
   ) u_in (
      .sel_flat (sel_flat),
      .pad_in   (pad_in),
      .fn_in    (fn_in)
   );

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad_chk
      // R5: an idle pad neither drives nor enables
      a_r5_idle_pad: assert property (@(posedge clk) disable iff (!rst_n)
         (sel_flat[p*SEL_W +: SEL_W] == '0) |-> (!pad_out[p] && !pad_oe[p]));
   end

   for (genvar f = 0; f < NUM_FUNCS; f++) begin : g_fn_chk
      if (FUNC_KIND[2*f+1 -: 2] == FK_OUT) begin : g_out_only
         // R9: an output-only function never sees a returned value
         a_r9_out_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !fn_in[f]);
      end
   end

   // R9: a returned value needs some pad input high
   a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_in == '0) |-> (fn_in == '0));

endmodule

// File: tb/tb_padmux.sv
module tb_padmux;

   localparam int CLK_PERIOD = 10;
   localparam int NP = 4;
   localparam int NF = 6;
   localparam int DW = 32;
   localparam int AW = 8;
   localparam int NV = 6;

   // function kinds: f0 bidir, f1 out, f2 in, f3 bidir, f4 out, f5 in
   // pad p choice c -> function (p+c-1) mod 6
   typedef struct packed {
      logic [1:0] c3, c2, c1, c0;
      logic [5:0] fo, foe;
      logic [3:0] pin;
      logic [3:0] pout, poe;
      logic [5:0] fin;
   } route_vec_t;

   localparam route_vec_t VEC [NV] = '{
      '{2'd1, 2'd1, 2'd1, 2'd1, 6'b111111, 6'b001001, 4'b1111, 4'b1011, 4'b1011, 6'b001101},
      '{2'd1, 2'd1, 2'd1, 2'd1, 6'b010110, 6'b000000, 4'b0101, 4'b0010, 4'b0010, 6'b000101},
      '{2'd3, 2'd3, 2'd2, 2'd3, 6'b010000, 6'b111111, 4'b1010, 4'b0100, 4'b0100, 6'b100000},
      '{2'd0, 2'd0, 2'd0, 2'd0, 6'b111111, 6'b111111, 4'b1111, 4'b0000, 4'b0000, 6'b000000},
      '{2'd0, 2'd2, 2'd3, 2'd2, 6'b001010, 6'b001000, 4'b0100, 4'b0111, 4'b0111, 6'b000000},
      '{2'd2, 2'd1, 2'd3, 2'd1, 6'b100001, 6'b000000, 4'b1011, 4'b0001, 4'b1000, 6'b001001}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_wdata = '0;
   logic          cfg_wr_err;
   logic [DW-1:0] cfg_rdata;
   logic          cfg_rd_err;
   logic [NP-1:0] pad_out, pad_oe;
   logic [NP-1:0] pad_in = '1;
   logic [NF-1:0] fn_out = '1, fn_oe = '1;
   logic [NF-1:0] fn_in;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   padmux dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_wr_err(cfg_wr_err), .cfg_rdata(cfg_rdata),
      .cfg_rd_err(cfg_rd_err), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_in(pad_in), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in)
   );

   function automatic string vec_tag(input int v);
      case (v)
         0: return "R6 R7 R8";
         1: return "R7 R9";
         2: return "R10 R8";
         3: return "R5";
         4: return "R10 R7";
         default: return "R6 R7 R9";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic exp_err, input string tag);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      #1 check({tag, " wr_err"}, 64'(cfg_wr_err), 64'(exp_err));
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp_d,
                          input logic exp_err, input string tag);
      @(negedge clk);
      cfg_wr = 1'b0; cfg_addr = a;
      #1;
      check({tag, " rdata"}, 64'(cfg_rdata), 64'(exp_d));
      check({tag, " rd_err"}, 64'(cfg_rd_err), 64'(exp_err));
   endtask

   task automatic quiet_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state with every peripheral and pad input high
      #1;
      check("R1 pad_out", 64'(pad_out), 64'h0);
      check("R1 pad_oe", 64'(pad_oe), 64'h0);
      check("R1 fn_in", 64'(fn_in), 64'h0);
      for (int k = 0; k < NP; k++) do_read(AW'(k * 4), '0, 1'b0, "R1 reset read");

      // R2: truncation on write, zero-extension on read
      do_write(8'h04, 32'hFFFF_FFFE, 1'b0, "R2");
      do_read(8'h04, 32'h2, 1'b0, "R2 truncated");

      // R4: stray address bits outside [4:2] ignored
      do_write(8'h8B, 32'h3, 1'b0, "R4 alias write");
      do_read(8'h08, 32'h3, 1'b0, "R4 plain read");
      do_read(8'h4B, 32'h3, 1'b0, "R4 alias read");

      // R3: unmapped indices 4 and 7
      do_write(8'h10, 32'h1, 1'b1, "R3 bad write");
      do_write(8'h1C, 32'h3, 1'b1, "R3 bad write hi");
      do_read(8'h00, 32'h0, 1'b0, "R3 pad0 kept");
      do_read(8'h04, 32'h2, 1'b0, "R3 pad1 kept");
      do_read(8'h08, 32'h3, 1'b0, "R3 pad2 kept");
      do_read(8'h0C, 32'h0, 1'b0, "R3 pad3 kept");
      do_read(8'h10, 32'h0, 1'b1, "R3 bad read");
      do_read(8'h1F, 32'h0, 1'b1, "R3 bad read hi");

      // routing vectors (R5..R10)
      for (int v = 0; v < NV; v++) begin
         quiet_write(8'h00, 32'(VEC[v].c0));
         quiet_write(8'h04, 32'(VEC[v].c1));
         quiet_write(8'h08, 32'(VEC[v].c2));
         quiet_write(8'h0C, 32'(VEC[v].c3));
         @(negedge clk);
         fn_out = VEC[v].fo; fn_oe = VEC[v].foe; pad_in = VEC[v].pin;
         #1;
         check({vec_tag(v), " pad_out"}, 64'(pad_out), 64'(VEC[v].pout));
         check({vec_tag(v), " pad_oe"}, 64'(pad_oe), 64'(VEC[v].poe));
         check({vec_tag(v), " fn_in"}, 64'(fn_in), 64'(VEC[v].fin));
      end

      // R7: bidirectional pad 0 (f0) follows its function's enable both ways
      quiet_write(8'h00, 32'h1);
      @(negedge clk);
      fn_out = 6'b000001; fn_oe = 6'b000000;
      #1 check("R7 oe low", 64'(pad_oe[0]), 64'h0);
      @(negedge clk);
      fn_oe = 6'b000001;
      #1 check("R7 oe high", 64'(pad_oe[0]), 64'h1);
      check("R7 data", 64'(pad_out[0]), 64'h1);

      // R1: reset in mid-run clears configured selects
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      fn_out = '1; fn_oe = '1; pad_in = '1;
      #1;
      check("R1 rerun pad_oe", 64'(pad_oe), 64'h0);
      check("R1 rerun fn_in", 64'(fn_in), 64'h0);
      do_read(8'h00, 32'h0, 1'b0, "R1 rerun read");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule